// File: doc/BRIEF.md
# Remote Memory Access Handshake Controller

This block connects one core's local memory to that core's network link. Other cores send it framed requests: read, write, acquire a lock region, or release a lock region. The block checks the lock table, performs the memory access on a simple synchronous memory port, and answers with a framed reply. If the target region is held by another core, the request is dropped without a word. The requester then notices the missing reply and sends the request again.

On the outgoing side, the local core issues one command at a time. The block builds the request frame and waits for the matching reply. If no reply arrives within a programmable number of cycles, it sends the same frame again. After a fixed number of resends it gives up and raises a failure pulse.

Both link directions are byte streams with a valid/ready handshake:

- **Receive side.** A byte moves when `rx_valid` and `rx_ready` are both high at a rising edge. The block drops `rx_ready` while a parsed request is waiting for the memory side.
- **Transmit side.** Once `tx_valid` is high, `tx_valid` and `tx_data` stay unchanged until `tx_ready` takes the byte. The link may hold `tx_ready` low for any length of time.

Top module: `rmh_ctrl`

## Requirements
- R1: Every transmitted frame has this layout: start byte 0x7E, bit-count byte equal to 8 times the payload byte count, the `my_id` byte, a message byte, the payload bytes, and a check byte. The message byte carries the message code in bits 3:0 and zero in bits 7:4. The check byte is chosen so that the XOR of every byte after the start byte, check byte included, is zero.
- R2: Message codes and payloads are:
  - read request = 1, payload address
  - read reply = 2, payload address then data
  - write = 3, payload address then data
  - acquire = 4, payload region byte
  - release = 5, payload region byte
  - acknowledge = 6, payload one echoed byte

  A read request from a core that is not blocked produces a read reply carrying the address and the memory data.
- R3: A write from a core that is not blocked writes the data to memory and produces an acknowledge echoing the address.
- R4: An address's lock region is its top `REG_W` address bits. With the defaults this gives four 64-byte regions. A read or write to a region locked by a different source makes no memory access and sends no reply.
- R5: An acquire names its region in the low `REG_W` bits of the region byte. It is granted, with an acknowledge echoing the region byte, when the region is free or already owned by the same source. Otherwise it gets no reply and the lock is unchanged.
- R6: A release from the owner, or for a free region, leaves the region free and is acknowledged. A release from a non-owner gets no reply, and the region stays locked.
- R7: A received frame is discarded in any of these cases:
  - the XOR check fails
  - the bit count is not a multiple of 8 up to 16
  - the message code is unknown
  - the payload length does not fit the code

  A discarded frame raises a one-cycle `rx_err` pulse, sends no reply and makes no memory access.
- R8: A local command maps `cmd_op` to a message as follows: 0 = read, 1 = write, 2 = acquire, 3 = release. The block sends the matching request frame. On a matching reply it pulses `cmd_done`, and for a read it presents the data on `cmd_rdata`.
- R9: If no matching reply arrives within `timeout_cycles` cycles of a send, the identical frame is sent again. After `RETRY_MAX` resends (4 frames in all with the default of 3), `cmd_fail` pulses and `cmd_done` does not.
- R10: `cmd_ready` stays low from command acceptance until `cmd_done` or `cmd_fail`, so an acquire stalls later commands until it is granted.
- R11: Both stream interfaces obey valid/ready back-pressure: transmit data stays stable while stalled, and `rx_ready` is low while a parsed request is pending.
- R12: When a reply to a remote core and a local request frame are both waiting, the reply is transmitted first.
- R13: A reply of the wrong message type, or with a mismatching echoed byte, does not complete the pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_id | input | 8 | Identifier of this core, placed in every sent frame |
| timeout_cycles | input | TMO_W | Reply wait per attempt, in cycles |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive byte accepted |
| rx_data | input | 8 | Receive byte |
| rx_err | output | 1 | One-cycle pulse on a discarded frame |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Link takes transmit byte |
| tx_data | output | 8 | Transmit byte |
| cmd_valid | input | 1 | Local command request |
| cmd_ready | output | 1 | Requester idle, command accepted |
| cmd_op | input | 2 | 0 read, 1 write, 2 acquire, 3 release |
| cmd_addr | input | 8 | Address or region byte |
| cmd_wdata | input | 8 | Write data |
| cmd_done | output | 1 | Command completed pulse |
| cmd_fail | output | 1 | Retries exhausted pulse |
| cmd_rdata | output | 8 | Read data of the last completed read |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a read |

## Verification
The bench uses the default parameters and drives `timeout_cycles` at 200:

- **Lock regions.** `ADDR_W` of 8 and `REG_W` of 2 give four 64-byte lock regions, so a locked region and a free region can be exercised side by side with one-byte addresses.
- **Retries.** `RETRY_MAX` of 3 makes exhaustion a short four-frame sequence.
- **Reply ordering.** The 200-cycle wait leaves room to inject wrong replies before the right one arrives.

Transmit back-pressure is randomized in some phases and held fully low in the priority phase. This forces a remote reply and a local request to wait for the link at the same time.

// File: rtl/rmh_pkg.sv
package rmh_pkg;
  localparam logic [7:0] SOF_BYTE = 8'h7E;

  localparam logic [3:0] MSG_RD_REQ = 4'd1;
  localparam logic [3:0] MSG_RD_RSP = 4'd2;
  localparam logic [3:0] MSG_WR     = 4'd3;
  localparam logic [3:0] MSG_ACQ    = 4'd4;
  localparam logic [3:0] MSG_REL    = 4'd5;
  localparam logic [3:0] MSG_ACK    = 4'd6;
  localparam logic [3:0] MSG_BAD    = 4'hF;

  typedef struct packed {
    logic [7:0] src;
    logic [3:0] msg;
    logic [7:0] b0;
    logic [7:0] b1;
  } frame_t;

  typedef struct packed {
    logic [3:0] msg;
    logic [1:0] nbytes;
    logic [7:0] b0;
    logic [7:0] b1;
  } desc_t;

  // payload bytes a message code must carry; 3 marks an unknown code
  function automatic logic [1:0] payload_len(input logic [3:0] m);
    case (m)
      MSG_RD_REQ, MSG_ACQ, MSG_REL, MSG_ACK: payload_len = 2'd1;
      MSG_RD_RSP, MSG_WR:                    payload_len = 2'd2;
      default:                               payload_len = 2'd3;
    endcase
  endfunction

  function automatic logic is_reply(input logic [3:0] m);
    is_reply = (m == MSG_RD_RSP) || (m == MSG_ACK);
  endfunction
endpackage

// File: rtl/rmh_rx_parser.sv
module rmh_rx_parser
  import rmh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       frm_valid,
  input  logic       frm_ready,
  output frame_t     frm,
  output logic       rx_err
);
  typedef enum logic [2:0] {P_HUNT, P_LEN, P_SRC, P_MSG, P_PAY, P_PAR, P_HOLD} pst_e;
  pst_e       st;
  logic [7:0] acc;
  logic [1:0] need, got;
  frame_t     cur;
  logic       beat;
  logic [7:0] acc_n;

  assign rx_ready  = (st != P_HOLD);
  assign frm_valid = (st == P_HOLD);
  assign frm       = cur;
  assign beat      = rx_valid && rx_ready;
  assign acc_n     = acc ^ rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= P_HUNT;
      acc    <= '0;
      need   <= '0;
      got    <= '0;
      cur    <= '0;
      rx_err <= 1'b0;
    end else begin
      rx_err <= 1'b0;
      case (st)
        P_HUNT: if (beat && rx_data == SOF_BYTE) st <= P_LEN;
        P_LEN: if (beat) begin
          acc <= rx_data;
          if (rx_data[2:0] != 3'd0 || rx_data[7:3] > 5'd2) begin
            rx_err <= 1'b1;
            st     <= P_HUNT;
          end else begin
            need <= rx_data[4:3];
            st   <= P_SRC;
          end
        end
        P_SRC: if (beat) begin
          acc     <= acc_n;
          cur.src <= rx_data;
          st      <= P_MSG;
        end
        P_MSG: if (beat) begin
          acc     <= acc_n;
          cur.msg <= (rx_data[7:4] == 4'd0) ? rx_data[3:0] : MSG_BAD;
          cur.b0  <= '0;
          cur.b1  <= '0;
          got     <= '0;
          st      <= (need == 2'd0) ? P_PAR : P_PAY;
        end
        P_PAY: if (beat) begin
          acc <= acc_n;
          if (got == 2'd0) cur.b0 <= rx_data;
          else             cur.b1 <= rx_data;
          got <= got + 2'd1;
          if (got + 2'd1 == need) st <= P_PAR;
        end
        P_PAR: if (beat) begin
          if (acc_n == 8'd0 && payload_len(cur.msg) == need) begin
            st <= P_HOLD;
          end else begin
            rx_err <= 1'b1;
            st     <= P_HUNT;
          end
        end
        P_HOLD: if (frm_ready) st <= P_HUNT;
        default: st <= P_HUNT;
      endcase
    end
  end

  AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !frm_ready |=> frm_valid && $stable(frm)); // R11
  AST_ERR_NOT_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> !frm_valid); // R7
endmodule

// File: rtl/rmh_server.sv
module rmh_server
  import rmh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  frame_t            req,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              rep_valid,
  input  logic              rep_ready,
  output desc_t             rep
);
  localparam int NREG = 1 << REG_W;

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_RDW, S_REP} sst_e;
  sst_e             st;
  frame_t           f;
  logic [NREG-1:0]  lock_q;
  logic [7:0]       owner_q [NREG];
  logic [REG_W-1:0] acc_reg, sync_reg;
  logic             blocked, foreign, is_data;

  assign acc_reg   = f.b0[ADDR_W-1 -: REG_W];
  assign sync_reg  = f.b0[REG_W-1:0];
  assign blocked   = lock_q[acc_reg] && (owner_q[acc_reg] != f.src);
  assign foreign   = lock_q[sync_reg] && (owner_q[sync_reg] != f.src);
  assign is_data   = (f.msg == MSG_RD_REQ) || (f.msg == MSG_WR);

  assign req_ready = (st == S_IDLE);
  assign rep_valid = (st == S_REP);
  assign mem_en    = (st == S_EXEC) && is_data && !blocked;
  assign mem_we    = (f.msg == MSG_WR);
  assign mem_addr  = f.b0[ADDR_W-1:0];
  assign mem_wdata = f.b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      f      <= '0;
      rep    <= '0;
      lock_q <= '0;
      for (int i = 0; i < NREG; i++) owner_q[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          f  <= req;
          st <= S_EXEC;
        end
        S_EXEC: begin
          st <= S_IDLE;
          case (f.msg)
            MSG_RD_REQ: if (!blocked) begin
              rep <= '{msg: MSG_RD_RSP, nbytes: 2'd2, b0: f.b0, b1: 8'd0};
              st  <= S_RDW;
            end
            MSG_WR: if (!blocked) begin
              rep <= '{msg: MSG_ACK, nbytes: 2'd1, b0: f.b0, b1: 8'd0};
              st  <= S_REP;
            end
            MSG_ACQ: if (!foreign) begin
              lock_q[sync_reg]  <= 1'b1;
              owner_q[sync_reg] <= f.src;
              rep <= '{msg: MSG_ACK, nbytes: 2'd1, b0: f.b0, b1: 8'd0};
              st  <= S_REP;
            end
            MSG_REL: if (!foreign) begin
              lock_q[sync_reg] <= 1'b0;
              rep <= '{msg: MSG_ACK, nbytes: 2'd1, b0: f.b0, b1: 8'd0};
              st  <= S_REP;
            end
            default: st <= S_IDLE;
          endcase
        end
        S_RDW: begin
          rep.b1 <= mem_rdata;
          st     <= S_REP;
        end
        S_REP: if (rep_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RDW_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDW) |-> $past(mem_en && !mem_we)); // R2
  AST_REP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid && !rep_ready |=> rep_valid && $stable(rep)); // R11
  AST_MEM_ONLY_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !req_ready && !rep_valid); // R4
endmodule

// File: rtl/rmh_requester.sv
module rmh_requester
  import rmh_pkg::*;
#(
  parameter int TMO_W     = 16,
  parameter int RETRY_MAX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_addr,
  input  logic [7:0]       cmd_wdata,
  output logic             cmd_done,
  output logic             cmd_fail,
  output logic [7:0]       cmd_rdata,
  input  logic [TMO_W-1:0] timeout_cycles,
  input  logic             rsp_valid,
  input  frame_t           rsp,
  output logic             out_valid,
  input  logic             out_ready,
  output desc_t            out
);
  localparam int RW = (RETRY_MAX < 1) ? 1 : $clog2(RETRY_MAX + 1);

  typedef enum logic [1:0] {R_IDLE, R_SEND, R_WAIT} rst_e;
  rst_e             st;
  desc_t            q;
  logic [RW-1:0]    tries;
  logic [TMO_W-1:0] timer;
  logic             match, expired;
  desc_t            fresh;

  always_comb begin
    fresh = '{msg: MSG_RD_REQ, nbytes: 2'd1, b0: cmd_addr, b1: 8'd0};
    case (cmd_op)
      2'd1:    fresh = '{msg: MSG_WR,  nbytes: 2'd2, b0: cmd_addr, b1: cmd_wdata};
      2'd2:    fresh = '{msg: MSG_ACQ, nbytes: 2'd1, b0: cmd_addr, b1: 8'd0};
      2'd3:    fresh = '{msg: MSG_REL, nbytes: 2'd1, b0: cmd_addr, b1: 8'd0};
      default: ;
    endcase
  end

  assign match = rsp_valid && (st == R_WAIT) && (rsp.b0 == q.b0) &&
                 ((q.msg == MSG_RD_REQ) ? (rsp.msg == MSG_RD_RSP) : (rsp.msg == MSG_ACK));
  assign expired   = (timer == timeout_cycles);
  assign cmd_ready = (st == R_IDLE);
  assign out_valid = (st == R_SEND);
  assign out       = q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= R_IDLE;
      q         <= '0;
      tries     <= '0;
      timer     <= '0;
      cmd_done  <= 1'b0;
      cmd_fail  <= 1'b0;
      cmd_rdata <= '0;
    end else begin
      cmd_done <= 1'b0;
      cmd_fail <= 1'b0;
      case (st)
        R_IDLE: if (cmd_valid) begin
          q     <= fresh;
          tries <= '0;
          st    <= R_SEND;
        end
        R_SEND: if (out_ready) begin
          timer <= '0;
          st    <= R_WAIT;
        end
        R_WAIT: begin
          timer <= timer + 1'b1;
          if (match) begin
            cmd_done <= 1'b1;
            if (q.msg == MSG_RD_REQ) cmd_rdata <= rsp.b1;
            st <= R_IDLE;
          end else if (expired) begin
            if (int'(tries) >= RETRY_MAX) begin
              cmd_fail <= 1'b1;
              st       <= R_IDLE;
            end else begin
              tries <= tries + 1'b1;
              st    <= R_SEND;
            end
          end
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_done && cmd_fail)); // R9
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done || cmd_fail) |-> cmd_ready); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out)); // R11
endmodule

// File: rtl/rmh_tx_framer.sv
module rmh_tx_framer
  import rmh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] my_id,
  input  logic       a_valid,
  output logic       a_ready,
  input  desc_t      a,
  input  logic       b_valid,
  output logic       b_ready,
  input  desc_t      b,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data
);
  logic       busy;
  logic [2:0] idx;
  desc_t      d;
  logic [7:0] id_q, len_b, msg_b, chk;
  logic [2:0] last;

  assign a_ready  = !busy;
  assign b_ready  = !busy && !a_valid;
  assign tx_valid = busy;
  assign len_b    = {3'd0, d.nbytes, 3'd0};
  assign msg_b    = {4'd0, d.msg};
  assign last     = 3'd4 + {1'b0, d.nbytes};
  assign chk      = len_b ^ id_q ^ msg_b ^
                    ((d.nbytes != 2'd0) ? d.b0 : 8'd0) ^
                    ((d.nbytes == 2'd2) ? d.b1 : 8'd0);

  always_comb begin
    case (idx)
      3'd0:    tx_data = SOF_BYTE;
      3'd1:    tx_data = len_b;
      3'd2:    tx_data = id_q;
      3'd3:    tx_data = msg_b;
      default: begin
        if (idx == last)      tx_data = chk;
        else if (idx == 3'd4) tx_data = d.b0;
        else                  tx_data = d.b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      d    <= '0;
      id_q <= '0;
    end else if (!busy) begin
      idx <= '0;
      if (a_valid) begin
        d    <= a;
        id_q <= my_id;
        busy <= 1'b1;
      end else if (b_valid) begin
        d    <= b;
        id_q <= my_id;
        busy <= 1'b1;
      end
    end else if (tx_ready) begin
      if (idx == last) busy <= 1'b0;
      idx <= idx + 3'd1;
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R11
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_valid && a_ready && b_valid && b_ready)); // R12
  AST_FRAME_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_data == SOF_BYTE); // R1
endmodule

// File: rtl/rmh_ctrl.sv
module rmh_ctrl
  import rmh_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_W     = 2,
  parameter int TMO_W     = 16,
  parameter int RETRY_MAX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        my_id,
  input  logic [TMO_W-1:0]  timeout_cycles,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              rx_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic              cmd_done,
  output logic              cmd_fail,
  output logic [7:0]        cmd_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  frame_t frm;
  logic   frm_valid, frm_ready, frm_is_rep;
  logic   srv_valid, srv_ready;
  logic   rep_valid, rep_ready, out_valid, out_ready;
  desc_t  rep, out;

  assign frm_is_rep = is_reply(frm.msg);
  assign srv_valid  = frm_valid && !frm_is_rep;
  assign frm_ready  = frm_is_rep ? 1'b1 : srv_ready;

  rmh_rx_parser u_parser (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm(frm), .rx_err(rx_err)
  );

  rmh_server #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_server (
    .clk(clk), .rst_n(rst_n),
    .req_valid(srv_valid), .req_ready(srv_ready), .req(frm),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rep_valid(rep_valid), .rep_ready(rep_ready), .rep(rep)
  );

  rmh_requester #(.TMO_W(TMO_W), .RETRY_MAX(RETRY_MAX)) u_requester (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_fail(cmd_fail), .cmd_rdata(cmd_rdata),
    .timeout_cycles(timeout_cycles),
    .rsp_valid(frm_valid && frm_is_rep), .rsp(frm),
    .out_valid(out_valid), .out_ready(out_ready), .out(out)
  );

  rmh_tx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .my_id(my_id),
    .a_valid(rep_valid), .a_ready(rep_ready), .a(rep),
    .b_valid(out_valid), .b_ready(out_ready), .b(out),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  AST_RX_STALL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> frm_valid); // R11
endmodule

// File: tb/rmh_ctrl_tb_top.sv
module rmh_ctrl_tb_top;
  localparam logic [7:0] MY_ID = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] timeout_cycles = 16'd200;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_ready, rx_err, tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [7:0]  cmd_addr = 8'h00, cmd_wdata = 8'h00;
  logic        cmd_ready, cmd_done, cmd_fail;
  logic [7:0]  cmd_rdata;
  logic        mem_en, mem_we;
  logic [7:0]  mem_addr, mem_wdata;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem [256];

  int total = 0, bad = 0;
  int err_cnt = 0, done_cnt = 0, fail_cnt = 0;
  logic [7:0] expq [$];
  logic bp_on = 1'b0, hold_tx = 1'b0;
  logic [7:0] lfsr = 8'hA1;
  logic prev_stall = 1'b0;
  logic [7:0] prev_data = 8'h00;

  always #4 clk = ~clk;

  rmh_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .my_id(MY_ID), .timeout_cycles(timeout_cycles),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_err(rx_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_fail(cmd_fail), .cmd_rdata(cmd_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5C;
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  always @(posedge clk) begin
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready <= hold_tx ? 1'b0 : (bp_on ? lfsr[0] : 1'b1);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected link bytes as the design sends them
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) chk(tx_valid && tx_data == prev_data, "R11", "stalled byte changed", int'(tx_data), int'(prev_data));
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      if (tx_valid && tx_ready) begin
        if (expq.size() == 0) chk(1'b0, "R4/R5/R6/R7", "unexpected tx byte", int'(tx_data), -1);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(tx_data == e, "R1", "tx byte", int'(tx_data), int'(e));
        end
      end
      if (rx_err)   err_cnt++;
      if (cmd_done) done_cnt++;
      if (cmd_fail) fail_cnt++;
    end
  end

  task automatic push_frame(input logic [3:0] msg, input int nb, input logic [7:0] b0, input logic [7:0] b1);
    logic [7:0] len, p;
    len = 8'(nb * 8);
    p = len ^ MY_ID ^ {4'd0, msg};
    if (nb >= 1) p ^= b0;
    if (nb == 2) p ^= b1;
    expq.push_back(8'h7E); expq.push_back(len); expq.push_back(MY_ID); expq.push_back({4'd0, msg});
    if (nb >= 1) expq.push_back(b0);
    if (nb == 2) expq.push_back(b1);
    expq.push_back(p);
  endtask

  task automatic put_byte(input logic [7:0] b);
    bit ok;
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    forever begin
      ok = rx_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
  endtask

  task automatic send_raw(input logic [7:0] len, input logic [7:0] src, input logic [7:0] mb,
                          input int nb, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] flip);
    logic [7:0] p;
    p = len ^ src ^ mb ^ flip;
    if (nb >= 1) p ^= b0;
    if (nb == 2) p ^= b1;
    put_byte(8'h7E); put_byte(len); put_byte(src); put_byte(mb);
    if (nb >= 1) put_byte(b0);
    if (nb == 2) put_byte(b1);
    put_byte(p);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] src, input logic [3:0] msg, input int nb, input logic [7:0] b0, input logic [7:0] b1);
    send_raw(8'(nb * 8), src, {4'd0, msg}, nb, b0, b1, 8'h00);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (expq.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    chk(expq.size() == 0, req, "expected frame not sent, bytes left", expq.size(), 0);
  endtask

  task automatic quiet(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [7:0] w);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input int base, input string req);
    int n = 0;
    while (done_cnt == base && n < 500) begin @(negedge clk); n++; end
    chk(done_cnt == base + 1, req, "cmd_done count", done_cnt, base + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d0, e0;
    repeat (4) @(negedge clk);
    // reset state
    chk(!tx_valid, "R11", "reset tx_valid", int'(tx_valid), 0);
    chk(rx_ready, "R11", "reset rx_ready", int'(rx_ready), 1);
    chk(cmd_ready, "R10", "reset cmd_ready", int'(cmd_ready), 1);
    chk(!mem_en && !rx_err && !cmd_done && !cmd_fail, "R1", "reset strobes", 0, 0);
    rst_n = 1'b1;
    quiet(2);

    // R2 remote read, random back-pressure
    bp_on = 1'b1;
    push_frame(4'd2, 2, 8'h10, 8'h10 ^ 8'h5C);
    send(8'h21, 4'd1, 1, 8'h10, 8'h00);
    drain("R2");
    // R3 remote write then read back
    push_frame(4'd6, 1, 8'h11, 8'h00);
    send(8'h21, 4'd3, 2, 8'h11, 8'h3C);
    drain("R3");
    chk(mem[8'h11] == 8'h3C, "R3", "memory after write", int'(mem[8'h11]), 'h3C);
    bp_on = 1'b0;

    // R5 acquire region 1 by 0x21
    push_frame(4'd6, 1, 8'h01, 8'h00);
    send(8'h21, 4'd4, 1, 8'h01, 8'h00);
    drain("R5");
    // R4 foreign read/write blocked
    send(8'h33, 4'd1, 1, 8'h50, 8'h00);
    send(8'h33, 4'd3, 2, 8'h45, 8'hEE);
    quiet(30);
    chk(mem[8'h45] == (8'h45 ^ 8'h5C), "R4", "blocked write left memory", int'(mem[8'h45]), int'(8'h45 ^ 8'h5C));
    // R4 owner write allowed
    push_frame(4'd6, 1, 8'h46, 8'h00);
    send(8'h21, 4'd3, 2, 8'h46, 8'h99);
    drain("R4");
    chk(mem[8'h46] == 8'h99, "R4", "owner write", int'(mem[8'h46]), 'h99);
    // R5 foreign acquire dropped
    send(8'h33, 4'd4, 1, 8'h01, 8'h00);
    quiet(30);
    // R6 non-owner release dropped, lock stays
    send(8'h33, 4'd5, 1, 8'h01, 8'h00);
    send(8'h33, 4'd1, 1, 8'h50, 8'h00);
    quiet(30);
    // R6 owner release, then foreign read passes
    push_frame(4'd6, 1, 8'h01, 8'h00);
    send(8'h21, 4'd5, 1, 8'h01, 8'h00);
    drain("R6");
    push_frame(4'd2, 2, 8'h50, 8'h50 ^ 8'h5C);
    send(8'h33, 4'd1, 1, 8'h50, 8'h00);
    drain("R6");

    // R7 malformed frames
    e0 = err_cnt;
    send_raw(8'd16, 8'h21, 8'h03, 2, 8'h22, 8'hEE, 8'h01);
    send_raw(8'd12, 8'h21, 8'h01, 1, 8'h22, 8'h00, 8'h00);
    send_raw(8'd8, 8'h21, 8'h09, 1, 8'h22, 8'h00, 8'h00);
    send_raw(8'd16, 8'h21, 8'h01, 2, 8'h22, 8'h00, 8'h00);
    quiet(20);
    chk(err_cnt == e0 + 4, "R7", "rx_err pulses", err_cnt - e0, 4);
    chk(mem[8'h22] == (8'h22 ^ 8'h5C), "R7", "memory after bad frame", int'(mem[8'h22]), int'(8'h22 ^ 8'h5C));

    // R8 local read
    d0 = done_cnt;
    push_frame(4'd1, 1, 8'h20, 8'h00);
    issue(2'd0, 8'h20, 8'h00);
    drain("R8");
    send(8'h40, 4'd2, 2, 8'h20, 8'h77);
    wait_done(d0, "R8");
    chk(cmd_rdata == 8'h77, "R8", "cmd_rdata", int'(cmd_rdata), 'h77);

    // R13 wrong replies ignored
    d0 = done_cnt;
    push_frame(4'd3, 2, 8'h24, 8'h55);
    issue(2'd1, 8'h24, 8'h55);
    drain("R8");
    send(8'h40, 4'd6, 1, 8'h25, 8'h00);
    quiet(10);
    send(8'h40, 4'd2, 2, 8'h24, 8'h00);
    quiet(10);
    chk(done_cnt == d0, "R13", "done after wrong replies", done_cnt, d0);
    chk(!cmd_ready, "R10", "cmd_ready while pending", int'(cmd_ready), 0);
    send(8'h40, 4'd6, 1, 8'h24, 8'h00);
    wait_done(d0, "R13");

    // R9 retries exhausted on an unanswered acquire
    d0 = done_cnt; e0 = fail_cnt;
    for (int k = 0; k < 4; k++) push_frame(4'd4, 1, 8'h02, 8'h00);
    issue(2'd2, 8'h02, 8'h00);
    quiet(3);
    chk(!cmd_ready, "R10", "cmd_ready during acquire", int'(cmd_ready), 0);
    for (int n = 0; n < 2000 && fail_cnt == e0; n++) @(negedge clk);
    chk(fail_cnt == e0 + 1, "R9", "cmd_fail pulses", fail_cnt - e0, 1);
    chk(expq.size() == 0, "R9", "frames left unsent", expq.size(), 0);
    chk(done_cnt == d0, "R9", "cmd_done after failure", done_cnt, d0);
    quiet(250);

    // R12 reply before local request
    hold_tx = 1'b1;
    push_frame(4'd2, 2, 8'h12, 8'h12 ^ 8'h5C);
    push_frame(4'd2, 2, 8'h13, 8'h13 ^ 8'h5C);
    push_frame(4'd1, 1, 8'h30, 8'h00);
    send(8'h21, 4'd1, 1, 8'h12, 8'h00);
    send(8'h21, 4'd1, 1, 8'h13, 8'h00);
    d0 = done_cnt;
    issue(2'd0, 8'h30, 8'h00);
    quiet(5);
    hold_tx = 1'b0;
    drain("R12");
    send(8'h40, 4'd2, 2, 8'h30, 8'h99);
    wait_done(d0, "R12");
    chk(cmd_rdata == 8'h99, "R12", "cmd_rdata", int'(cmd_rdata), 'h99);

    quiet(10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule